// File: doc/BRIEF.md
# Repeated-Frame Zone Alarm Validator

This block sits behind the demodulator and signal conditioner of a wireless alarm receiver. It takes the cleaned-up serial line, recovers asynchronous 10-bit frames with a 16x oversampling receiver, and reads each frame as a 7-bit zone address plus an even-parity bit. Frames with a parity error are thrown away and counted. Frames with a bad stop bit are thrown away without being counted.

A zone alarm is declared only when three frames in a row pass all checks and carry the same address, with no long silence between them. Anything else is treated as line noise. Each confirmed triple produces a single-cycle valid pulse together with the zone address. A supervising controller can display or latch that address.

The alarm output is a valid-qualified data stream with no ready input. The serial line cannot be stalled, so there is no back-pressure: the consumer must take the address in the cycle the valid pulse is high. The address stays on its port until the next confirmation. The parity error count is a plain status output.

Top module: `alarm_frame_validator`

## Requirements
- R1: While reset is asserted and right after it, `alarm_valid_o` is 0, `alarm_addr_o` is 0 and `parity_err_cnt_o` is 0.
- R2: Frame format and bit timing.
  - A frame is a 0 start bit, then 8 data bits sent least significant bit first, then a 1 stop bit.
  - Each bit lasts 16*DIV clock cycles.
  - Data bits 0 to 6 are the zone address. Data bit 7 is the parity bit.
- R3: Confirmation.
  - When three consecutive accepted frames carry the same address, `alarm_valid_o` is high for exactly one cycle, during the stop bit of the third frame.
  - In that same cycle `alarm_addr_o` shows the address. The address then holds until the next confirmation.
  - Two accepted frames alone never produce a confirmation.
- R4: Parity errors. A frame is accepted only if the XOR of all 8 data bits is 0 (even parity). A frame that fails the check:
  - raises `parity_err_cnt_o` by exactly 1;
  - never confirms;
  - leaves the collection in progress untouched.
- R5: `parity_err_cnt_o` saturates at 2^ERR_W-1.
- R6: A frame whose stop bit reads 0 is discarded. It changes neither the error count nor the collection.
- R7: A low pulse on the line shorter than half a bit time is not taken as a start bit. It produces no frame.
- R8: An accepted frame whose address differs from the frames being collected restarts the collection. That frame becomes the first of a new triple.
- R9: If GAP_TICKS oversampling ticks pass after an accepted frame with no further accepted frame, the collection is cleared. The next accepted frame becomes the first of a new triple.
- R10: After a confirmation the collection is empty. A fourth identical frame counts as the first of the next triple, so six identical frames give exactly two confirmations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Conditioned serial line, idles high |
| alarm_valid_o | output | 1 | One-cycle confirmation pulse, no ready |
| alarm_addr_o | output | ADDR_W | Zone address of the last confirmed triple |
| parity_err_cnt_o | output | ERR_W | Saturating count of parity-failed frames |

## Verification
The assertions assume that the line driving `rx_i` holds each bit for a full bit time. In particular, they assume the stop bit of a good frame stays high for its whole period, so a confirmation always coincides with a high line. They also assume that accepted frames are at least one frame time apart, which keeps the confirmation pulse isolated.

The bench meets both assumptions by construction. It drives every bit for exactly 16*DIV cycles from its negative clock edge and always follows a frame with idle time. Short glitches appear only in the start-bit test, far from any stop bit.

// File: rtl/afv_pkg.sv
package afv_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/afv_tick_gen.sv
module afv_tick_gen #(
  parameter int DIV = 26042
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every_cycle
      assign tick = 1'b1;
    end else begin : g_divider
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign tick = (cnt == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/afv_uart_rx.sv
module afv_uart_rx
  import afv_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx,
  output logic             frame_ok,
  output logic [DBITS-1:0] frame_data
);
  localparam int CW   = $clog2(OVS);
  localparam int NBW  = $clog2(DBITS);
  localparam int HALF = OVS / 2;

  rx_state_t        st;
  logic [CW-1:0]    cnt;
  logic [NBW-1:0]   nbit;
  logic [DBITS-1:0] shreg;
  logic             s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      cnt        <= '0;
      nbit       <= '0;
      shreg      <= '0;
      frame_ok   <= 1'b0;
      frame_data <= '0;
      s1         <= 1'b1;
      s2         <= 1'b1;
    end else begin
      s1       <= rx;
      s2       <= s1;
      frame_ok <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            if (!s2) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            // re-check the start bit at its middle
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              if (!s2) begin
                st   <= RX_DATA;
                nbit <= '0;
              end else begin
                st <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt   <= '0;
              shreg <= {s2, shreg[DBITS-1:1]};
              if (nbit == NBW'(DBITS - 1)) begin
                st <= RX_STOP;
              end else begin
                nbit <= nbit + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              st  <= RX_IDLE;
              if (s2) begin
                frame_ok   <= 1'b1;
                frame_data <= shreg;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/afv_parity_gate.sv
module afv_parity_gate #(
  parameter int DBITS = 8,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_ok,
  input  logic [DBITS-1:0] frame_data,
  output logic             addr_valid,
  output logic [DBITS-2:0] addr,
  output logic [ERR_W-1:0] err_cnt
);
  logic odd;
  assign odd        = ^frame_data;
  assign addr_valid = frame_ok & ~odd;
  assign addr       = frame_data[DBITS-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
    end else if (frame_ok && odd && (err_cnt != {ERR_W{1'b1}})) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/afv_match_buf.sv
module afv_match_buf #(
  parameter int AW        = 7,
  parameter int REPEATS   = 3,
  parameter int GAP_TICKS = 4800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  output logic          confirm,
  output logic [AW-1:0] confirm_addr
);
  localparam int FW = $clog2(REPEATS + 1);
  localparam int GW = $clog2(GAP_TICKS + 1);

  logic [FW-1:0] fill;
  logic [AW-1:0] ref_addr;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill         <= '0;
      ref_addr     <= '0;
      gap          <= '0;
      confirm      <= 1'b0;
      confirm_addr <= '0;
    end else begin
      confirm <= 1'b0;
      if (in_valid) begin
        gap <= '0;
        if (fill == '0 || in_addr != ref_addr) begin
          ref_addr <= in_addr;
          fill     <= FW'(1);
        end else if (fill == FW'(REPEATS - 1)) begin
          fill         <= '0;
          confirm      <= 1'b1;
          confirm_addr <= in_addr;
        end else begin
          fill <= fill + 1'b1;
        end
      end else if (tick && fill != '0) begin
        if (gap == GW'(GAP_TICKS - 1)) begin
          fill <= '0;
          gap  <= '0;
        end else begin
          gap <= gap + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/alarm_frame_validator.sv
module alarm_frame_validator #(
  parameter int DIV       = 26042,
  parameter int OVS       = 16,
  parameter int ADDR_W    = 7,
  parameter int REPEATS   = 3,
  parameter int GAP_TICKS = 4800,
  parameter int ERR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  output logic              alarm_valid_o,
  output logic [ADDR_W-1:0] alarm_addr_o,
  output logic [ERR_W-1:0]  parity_err_cnt_o
);
  localparam int DBITS = ADDR_W + 1;

  logic             tick;
  logic             frame_ok;
  logic [DBITS-1:0] frame_data;
  logic             addr_valid;
  logic [ADDR_W-1:0] addr;

  afv_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  afv_uart_rx #(.OVS(OVS), .DBITS(DBITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_i),
    .frame_ok(frame_ok), .frame_data(frame_data)
  );

  afv_parity_gate #(.DBITS(DBITS), .ERR_W(ERR_W)) u_par (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_data(frame_data),
    .addr_valid(addr_valid), .addr(addr), .err_cnt(parity_err_cnt_o)
  );

  afv_match_buf #(.AW(ADDR_W), .REPEATS(REPEATS), .GAP_TICKS(GAP_TICKS)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .in_valid(addr_valid), .in_addr(addr),
    .confirm(alarm_valid_o), .confirm_addr(alarm_addr_o)
  );
endmodule

// File: rtl/afv_checker.sv
module afv_checker #(
  parameter int ADDR_W = 7,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_i,
  input logic              alarm_valid_o,
  input logic [ADDR_W-1:0] alarm_addr_o,
  input logic [ERR_W-1:0]  parity_err_cnt_o
);
  // R3: the confirmation pulse lasts a single cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_valid_o |=> !alarm_valid_o);

  // R3: the address only moves together with a confirmation
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm_addr_o) |-> alarm_valid_o);

  // R2: a confirmation lands inside a stop bit, so the line is high
  p_confirm_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_valid_o |-> rx_i);

  // R4: the error count moves in steps of one
  p_err_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(parity_err_cnt_o) |-> (parity_err_cnt_o == $past(parity_err_cnt_o) + ERR_W'(1)));

  // R4: a parity failure never confirms
  p_err_no_alarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(parity_err_cnt_o) |-> !alarm_valid_o);

  // R5: once full, the count stays full
  p_err_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err_cnt_o == {ERR_W{1'b1}}) |=> (parity_err_cnt_o == {ERR_W{1'b1}}));
endmodule

bind alarm_frame_validator afv_checker #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/test_alarm_frame_validator.sv
module test_alarm_frame_validator;
  localparam int DIV   = 1;
  localparam int GAP   = 400;
  localparam int ERR_W = 4;
  localparam int BT    = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic alarm_valid;
  logic [6:0] alarm_addr;
  logic [ERR_W-1:0] err_cnt;

  int n_tests = 0, n_fail = 0;
  int n_conf = 0, last_addr = 0, exp_err = 0;
  bit prev_valid = 1'b0;

  always #4 clk = ~clk;

  alarm_frame_validator #(.DIV(DIV), .GAP_TICKS(GAP), .ERR_W(ERR_W)) i_alarm_frame_validator (
    .clk(clk), .rst_n(rst_n), .rx_i(rx),
    .alarm_valid_o(alarm_valid), .alarm_addr_o(alarm_addr), .parity_err_cnt_o(err_cnt)
  );

  always @(negedge clk) begin
    if (rst_n && alarm_valid) begin
      n_conf++;
      last_addr = alarm_addr;
      if (prev_valid) begin
        n_tests++; n_fail++;
        $display("FAIL R3 strobe width: actual 2+ cycles expected 1");
      end
    end
    prev_valid = alarm_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic stop_b, input int idle_bits);
    @(negedge clk) rx = 1'b0;
    repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (BT) @(negedge clk);
    end
    rx = stop_b;
    repeat (BT) @(negedge clk);
    rx = 1'b1;
    repeat (BT * idle_bits) @(negedge clk);
  endtask

  task automatic good(input logic [6:0] a);
    send({^a, a}, 1'b1, 1);
  endtask

  task automatic bad(input logic [6:0] a);
    send({~^a, a}, 1'b1, 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (10) @(negedge clk);
    chk(alarm_valid == 0 && alarm_addr == 0 && err_cnt == 0, "R1 reset", int'(err_cnt), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(alarm_valid == 0 && alarm_addr == 0 && err_cnt == 0 && n_conf == 0, "R1 after reset", n_conf, 0);

    // R2 / R3 sweep over every address
    for (int a = 0; a < 128; a++) begin
      base = n_conf;
      good(7'(a)); good(7'(a));
      chk(n_conf == base, "R3 no confirm after two", n_conf - base, 0);
      good(7'(a));
      chk(n_conf == base + 1, "R3 confirm count", n_conf - base, 1);
      chk(last_addr == a, "R2 address bits", last_addr, a);
      chk(alarm_addr == 7'(a), "R3 address held", int'(alarm_addr), a);
    end

    // R4 parity failure in the middle of a collection
    base = n_conf;
    good(7'h35);
    bad(7'h35); exp_err++;
    chk(int'(err_cnt) == exp_err, "R4 error count", int'(err_cnt), exp_err);
    chk(n_conf == base, "R4 no confirm on bad", n_conf - base, 0);
    good(7'h35);
    chk(n_conf == base, "R4 two good so far", n_conf - base, 0);
    good(7'h35);
    chk(n_conf == base + 1 && last_addr == 'h35, "R4 collection kept", last_addr, 'h35);

    // R5 saturation
    for (int i = 0; i < 20; i++) begin
      bad(7'(i * 5));
      if (exp_err < 15) exp_err++;
      chk(int'(err_cnt) == exp_err, "R5 saturating count", int'(err_cnt), exp_err);
    end

    // R6 framing error
    base = n_conf;
    good(7'h5A); good(7'h5A);
    send({^7'h5A, 7'h5A}, 1'b0, 2);
    chk(n_conf == base, "R6 framing frame ignored", n_conf - base, 0);
    chk(int'(err_cnt) == exp_err, "R6 no error count", int'(err_cnt), exp_err);
    good(7'h5A);
    chk(n_conf == base + 1 && last_addr == 'h5A, "R6 collection kept", last_addr, 'h5A);

    // R7 short glitch
    base = n_conf;
    @(negedge clk) rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BT) @(negedge clk);
    chk(n_conf == base && int'(err_cnt) == exp_err, "R7 glitch no frame", n_conf - base, 0);
    good(7'h11); good(7'h11);
    chk(n_conf == base, "R7 glitch not counted", n_conf - base, 0);
    good(7'h11);
    chk(n_conf == base + 1 && last_addr == 'h11, "R7 confirm after glitch", last_addr, 'h11);

    // R8 mismatch restart
    base = n_conf;
    good(7'h20); good(7'h20); good(7'h21); good(7'h21);
    chk(n_conf == base, "R8 mismatch restarts", n_conf - base, 0);
    good(7'h21);
    chk(n_conf == base + 1 && last_addr == 'h21, "R8 newest is first", last_addr, 'h21);

    // R9 timeout restart
    base = n_conf;
    good(7'h44); good(7'h44);
    repeat (600) @(negedge clk);
    good(7'h44); good(7'h44);
    chk(n_conf == base, "R9 timeout restarts", n_conf - base, 0);
    good(7'h44);
    chk(n_conf == base + 1 && last_addr == 'h44, "R9 confirm after restart", last_addr, 'h44);

    // R10 empty after confirm
    base = n_conf;
    for (int i = 1; i <= 6; i++) begin
      good(7'h7F);
      chk(n_conf == base + i / 3, "R10 triples", n_conf - base, i / 3);
    end
    chk(last_addr == 'h7F, "R10 address", last_addr, 'h7F);

    summary();
    $finish;
  end
endmodule